// File: doc/BRIEF.md
# Grouped Event Performance Counter Unit

This unit counts hardware events for software profiling. Six 32-bit counters watch a 16-bit event bus, on which each bit is a one-cycle-per-occurrence event pulse. The events do not reach the counters directly. They pass through four shared routing lanes. Each counter picks one lane and one event number. A lane carries the event chosen by the lowest-indexed counter that uses it. Two counters on the same lane can therefore only both count if they want the same event. A complete setting of the three control registers makes up one event group, and software switches between such groups by rewriting them.

A single run bit starts and stops counters 0 to 3 together. Counters 4 and 5 are free-running: they count whenever their routed event is present, whatever the run bit says. Software reaches every counter, the three control registers and a sticky overflow status register through a simple register bus. Writes take effect at the clock edge. Read data appears one cycle after the address is presented. Writing a counter preloads it, and the preload wins over any increment in that cycle.

Top module: `grp_evt_pmu`

## Requirements
- R1: After synchronous active-high reset, all counters, all three control registers and the overflow status read as zero, and the gated counters are stopped.
- R2: Register addresses are: counters 0..5 at 0..5, run control at 8, event selects at 9, lane selects at 10, overflow status at 11. Read data is registered and is valid one cycle after the address. Unmapped addresses (6, 7, 12..15) read zero, and unused control bits read back as zero.
- R3: Control field layout: run is bit 0 of address 8. The event select of counter i is bits [4i+3:4i] of address 9. The lane select of counter i is bits [2i+1:2i] of address 10.
- R4: A counter adds one in every cycle in which its routed lane carries its selected event and that event bit is high.
- R5: Each lane carries the event chosen by the lowest-indexed counter selecting that lane. A counter on the same lane with a different event does not count. One with the same event counts.
- R6: Counters 0..3 count only while the run bit is 1. With run at 0 they hold their value.
- R7: Counters 4 and 5 count regardless of the run bit.
- R8: A bus write to a counter loads the written value, and the counter does not increment in that cycle.
- R9: A control-register write takes effect from the next cycle. An event in the cycle of the write is counted under the old setting.
- R10: When an increment wraps counter i from all ones to zero, status bit i becomes 1 and stays 1. Writing 1 to that bit clears it, writing 0 leaves it, and a bus write of any value to a counter never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 4 | Register bus address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after the address |
| eventBus | input | 16 | Event pulse inputs, one bit per event number |

## Verification
A wrong lane-owner decision shows up as a counter that stays frozen, or counts, on the very next read after an event burst. The cause is often the other counter sharing that lane. A run bit applied one cycle early or late, or a preload that also increments, moves the affected counter by exactly one. A single read exposes that. Overflow mishandling appears in the status register on the first read after the wrap: a flag missing, set by a mere preload, or lost after a write of zero.

// File: rtl/gpmu_pkg.sv
package gpmu_pkg;
  localparam int CNT_NUM   = 6;
  localparam int CNT_BITS  = 32;
  localparam int ADDR_RUN  = 8;
  localparam int ADDR_EVT  = 9;
  localparam int ADDR_LANE = 10;
  localparam int ADDR_STAT = 11;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic [CNT_NUM-1:0]  cntWr;
    logic [CNT_BITS-1:0] wrData;
  } pmuStrobe_t;
endpackage

// File: rtl/gpmu_ctrl.sv
module gpmu_ctrl
  import gpmu_pkg::*;
#(
  parameter int NUM_CNT   = 6,
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 16,
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [ADDR_W-1:0]                         regAddr,
  input  logic                                      regWe,
  input  logic [CNT_W-1:0]                          regWdata,
  output logic [CNT_W-1:0]                          regRdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]             cntVal,
  input  logic [NUM_CNT-1:0]                        wrapHit,
  output logic                                      runEn,
  output logic [NUM_CNT-1:0][$clog2(EVT_W)-1:0]     evtSel,
  output logic [NUM_CNT-1:0][$clog2(NUM_LANES)-1:0] laneSel,
  output pmuStrobe_t                                stb
);
  localparam int SEL_W  = $clog2(EVT_W);
  localparam int LANE_W = $clog2(NUM_LANES);

  logic                              runQ;
  logic [NUM_CNT-1:0][SEL_W-1:0]     evtQ;
  logic [NUM_CNT-1:0][LANE_W-1:0]    laneQ;
  logic [NUM_CNT-1:0]                ovfQ;
  logic [NUM_CNT-1:0]                ovfClr;
  logic [CNT_W-1:0]                  rdNext;
  logic [CNT_W-1:0]                  rdQ;

  wire wrRun  = regWe && (regAddr == ADDR_W'(ADDR_RUN));
  wire wrEvt  = regWe && (regAddr == ADDR_W'(ADDR_EVT));
  wire wrLane = regWe && (regAddr == ADDR_W'(ADDR_LANE));
  wire wrStat = regWe && (regAddr == ADDR_W'(ADDR_STAT));

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      stb.cntWr[i] = regWe && (regAddr == ADDR_W'(i));
    end
    stb.wrData = regWdata;
    ovfClr = wrStat ? regWdata[NUM_CNT-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ  <= 1'b0;
      evtQ  <= '0;
      laneQ <= '0;
      ovfQ  <= '0;
    end else begin
      if (wrRun)  runQ  <= regWdata[0];
      if (wrEvt)  evtQ  <= regWdata[NUM_CNT*SEL_W-1:0];
      if (wrLane) laneQ <= regWdata[NUM_CNT*LANE_W-1:0];
      ovfQ <= (ovfQ & ~ovfClr) | wrapHit;   // a new wrap beats a clear
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == ADDR_W'(i)) rdNext = cntVal[i];
    end
    if (regAddr == ADDR_W'(ADDR_RUN))  rdNext = CNT_W'(runQ);
    if (regAddr == ADDR_W'(ADDR_EVT))  rdNext = CNT_W'(evtQ);
    if (regAddr == ADDR_W'(ADDR_LANE)) rdNext = CNT_W'(laneQ);
    if (regAddr == ADDR_W'(ADDR_STAT)) rdNext = CNT_W'(ovfQ);
  end

  always_ff @(posedge clk) begin
    if (rst) rdQ <= '0;
    else     rdQ <= rdNext;
  end

  assign regRdata = rdQ;
  assign runEn    = runQ;
  assign evtSel   = evtQ;
  assign laneSel  = laneQ;

  AST_CFG_NEXT: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == ADDR_W'(ADDR_RUN)) |=> (runEn == $past(regWdata[0]))); // R9

  AST_RDATA_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    ((regAddr >= ADDR_W'(NUM_CNT) && regAddr < ADDR_W'(ADDR_RUN)) ||
     regAddr > ADDR_W'(ADDR_STAT)) |=> (regRdata == '0)); // R2

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ovf_chk
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovfQ[g] && !(wrStat && regWdata[g])) |=> ovfQ[g]); // R10
  end
endmodule

// File: rtl/gpmu_datapath.sv
module gpmu_datapath
  import gpmu_pkg::*;
#(
  parameter int NUM_CNT   = 6,
  parameter int NUM_FREE  = 2,
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 16,
  parameter int NUM_LANES = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [EVT_W-1:0]                          eventBus,
  input  logic                                      runEn,
  input  logic [NUM_CNT-1:0][$clog2(EVT_W)-1:0]     evtSel,
  input  logic [NUM_CNT-1:0][$clog2(NUM_LANES)-1:0] laneSel,
  input  pmuStrobe_t                                stb,
  output logic [NUM_CNT-1:0][CNT_W-1:0]             cntVal,
  output logic [NUM_CNT-1:0]                        wrapHit
);
  localparam int SEL_W      = $clog2(EVT_W);
  localparam int FIRST_FREE = NUM_CNT - NUM_FREE;

  logic [NUM_LANES-1:0]            laneUsed;
  logic [NUM_LANES-1:0][SEL_W-1:0] laneEvt;
  logic [NUM_LANES-1:0]            laneBit;
  logic [NUM_CNT-1:0]              hit;
  logic [NUM_CNT-1:0]              incEn;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cntQ;

  // lane routing: walk from the top so the lowest-indexed user claims the lane
  always_comb begin
    laneUsed = '0;
    laneEvt  = '0;
    for (int i = NUM_CNT - 1; i >= 0; i--) begin
      laneUsed[laneSel[i]] = 1'b1;
      laneEvt[laneSel[i]]  = evtSel[i];
    end
    for (int k = 0; k < NUM_LANES; k++) begin
      laneBit[k] = laneUsed[k] && eventBus[laneEvt[k]];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      hit[i] = laneBit[laneSel[i]] && (laneEvt[laneSel[i]] == evtSel[i]);
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    if (g >= FIRST_FREE) begin : g_free
      assign incEn[g] = hit[g] && !stb.cntWr[g];
      AST_FREE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (hit[g] && !stb.cntWr[g]) |=> (cntQ[g] == $past(cntQ[g]) + CNT_W'(1))); // R7
    end else begin : g_gated
      assign incEn[g] = hit[g] && runEn && !stb.cntWr[g];
      AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!runEn && !stb.cntWr[g]) |=> $stable(cntQ[g])); // R6
    end

    assign wrapHit[g] = incEn[g] && (cntQ[g] == '1);

    always_ff @(posedge clk) begin
      if (rst)                cntQ[g] <= '0;
      else if (stb.cntWr[g])  cntQ[g] <= stb.wrData;
      else if (incEn[g])      cntQ[g] <= cntQ[g] + CNT_W'(1);
    end

    AST_WRITE_NO_INC: assert property (@(posedge clk) disable iff (rst)
      stb.cntWr[g] |=> (cntQ[g] == $past(stb.wrData))); // R8
  end

  assign cntVal = cntQ;
endmodule

// File: rtl/grp_evt_pmu.sv
module grp_evt_pmu
  import gpmu_pkg::*;
#(
  parameter int NUM_CNT   = gpmu_pkg::CNT_NUM,
  parameter int NUM_FREE  = 2,
  parameter int CNT_W     = gpmu_pkg::CNT_BITS,
  parameter int EVT_W     = 16,
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [EVT_W-1:0]  eventBus
);
  localparam int SEL_W  = $clog2(EVT_W);
  localparam int LANE_W = $clog2(NUM_LANES);

  logic                           runEn;
  logic [NUM_CNT-1:0][SEL_W-1:0]  evtSel;
  logic [NUM_CNT-1:0][LANE_W-1:0] laneSel;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cntVal;
  logic [NUM_CNT-1:0]             wrapHit;
  pmuStrobe_t                     stb;

  gpmu_ctrl #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W),
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .cntVal(cntVal),
    .wrapHit(wrapHit), .runEn(runEn), .evtSel(evtSel),
    .laneSel(laneSel), .stb(stb)
  );

  gpmu_datapath #(
    .NUM_CNT(NUM_CNT), .NUM_FREE(NUM_FREE), .CNT_W(CNT_W),
    .EVT_W(EVT_W), .NUM_LANES(NUM_LANES)
  ) dp_i (
    .clk(clk), .rst(rst), .eventBus(eventBus), .runEn(runEn),
    .evtSel(evtSel), .laneSel(laneSel), .stb(stb),
    .cntVal(cntVal), .wrapHit(wrapHit)
  );
endmodule

// File: tb/grp_evt_pmu_tb_top.sv
module grp_evt_pmu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] eventBus = '0;

  int checkCnt = 0;
  int failCnt  = 0;

  localparam logic [3:0] A_RUN = 4'd8, A_EVT = 4'd9, A_LANE = 4'd10, A_STAT = 4'd11;

  always #2 clk = ~clk;   // 250 MHz

  grp_evt_pmu dut_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .eventBus(eventBus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b0;
    @(negedge clk);
    d = regRdata;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(input logic [15:0] mask, input int n);
    @(negedge clk);
    eventBus = mask;
    repeat (n) @(negedge clk);
    eventBus = '0;
  endtask

  function automatic logic [31:0] mkEvt(input logic [3:0] e0, e1, e2, e3, e4, e5);
    return {8'h00, e5, e4, e3, e2, e1, e0};
  endfunction

  function automatic logic [31:0] mkLane(input logic [1:0] l0, l1, l2, l3, l4, l5);
    return {20'h0, l5, l4, l3, l2, l1, l0};
  endfunction

  task automatic clearCounters();
    for (int i = 0; i < 6; i++) regWrite(4'(i), 32'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) expectReg("R1 counter after reset", 4'(i), 32'h0);
    expectReg("R1 run reg", A_RUN, 32'h0);
    expectReg("R1 event reg", A_EVT, 32'h0);
    expectReg("R1 lane reg", A_LANE, 32'h0);
    expectReg("R1 status", A_STAT, 32'h0);
  endtask

  task automatic t_map();
    regWrite(A_EVT, 32'hFFFF_FFFF);
    expectReg("R2 event readback mask", A_EVT, 32'h00FF_FFFF);
    regWrite(A_LANE, 32'hFFFF_FFFF);
    expectReg("R2 lane readback mask", A_LANE, 32'h0000_0FFF);
    regWrite(A_RUN, 32'hFFFF_FFFF);
    expectReg("R2 run readback mask", A_RUN, 32'h1);
    expectReg("R2 unmapped 6", 4'd6, 32'h0);
    expectReg("R2 unmapped 15", 4'd15, 32'h0);
    regWrite(A_RUN, 32'h0);
    regWrite(A_EVT, 32'h0);
    regWrite(A_LANE, 32'h0);
  endtask

  task automatic t_count();
    regWrite(A_EVT,  mkEvt(4'd7, 4'd2, 4'd15, 4'd15, 4'd15, 4'd15));
    regWrite(A_LANE, mkLane(2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 2'd3));
    regWrite(A_RUN, 32'h1);
    clearCounters();
    pulse(16'h0080, 5);
    expectReg("R4 single event count", 4'd0, 32'd5);
    expectReg("R3 other field untouched", 4'd1, 32'd0);
    pulse(16'h0084, 3);
    expectReg("R4 two counters c0", 4'd0, 32'd8);
    expectReg("R4 two counters c1", 4'd1, 32'd3);
    regWrite(A_RUN, 32'h0);
    pulse(16'h0084, 4);
    expectReg("R6 stopped c0 holds", 4'd0, 32'd8);
    expectReg("R6 stopped c1 holds", 4'd1, 32'd3);
  endtask

  task automatic t_share();
    regWrite(A_EVT,  mkEvt(4'd9, 4'd3, 4'd5, 4'd5, 4'd3, 4'd10));
    regWrite(A_LANE, mkLane(2'd0, 2'd2, 2'd2, 2'd3, 2'd2, 2'd1));
    regWrite(A_RUN, 32'h1);
    clearCounters();
    pulse(16'h0028, 4);
    expectReg("R5 lane owner counts", 4'd1, 32'd4);
    expectReg("R5 conflicting event blocked", 4'd2, 32'd0);
    expectReg("R5 same event other lane", 4'd3, 32'd4);
    expectReg("R5 same event shared lane", 4'd4, 32'd4);
  endtask

  task automatic t_free();
    regWrite(A_RUN, 32'h0);
    regWrite(A_EVT,  mkEvt(4'd12, 4'd15, 4'd15, 4'd15, 4'd12, 4'd13));
    regWrite(A_LANE, mkLane(2'd0, 2'd3, 2'd3, 2'd3, 2'd0, 2'd1));
    clearCounters();
    pulse(16'h3000, 6);
    expectReg("R6 gated idle while stopped", 4'd0, 32'd0);
    expectReg("R7 free counter 4", 4'd4, 32'd6);
    expectReg("R7 free counter 5", 4'd5, 32'd6);
  endtask

  task automatic t_cfg_next();
    regWrite(A_RUN, 32'h0);
    regWrite(A_EVT,  mkEvt(4'd4, 4'd15, 4'd15, 4'd15, 4'd15, 4'd15));
    regWrite(A_LANE, mkLane(2'd0, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3));
    clearCounters();
    @(negedge clk);
    eventBus = 16'h0010;
    regAddr = A_RUN; regWdata = 32'h1; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; eventBus = '0;
    expectReg("R9 write-cycle event uses old run", 4'd0, 32'd0);
    expectReg("R9 run now set", A_RUN, 32'h1);
    pulse(16'h0010, 2);
    expectReg("R9 counts after write", 4'd0, 32'd2);
  endtask

  task automatic t_preload();
    @(negedge clk);
    eventBus = 16'h0010;
    regAddr = 4'd0; regWdata = 32'd100; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; eventBus = '0;
    expectReg("R8 preload without increment", 4'd0, 32'd100);
    pulse(16'h0010, 1);
    expectReg("R8 counts on from preload", 4'd0, 32'd101);
  endtask

  task automatic t_overflow();
    regWrite(A_EVT,  mkEvt(4'd15, 4'd15, 4'd15, 4'd15, 4'd15, 4'd6));
    regWrite(A_LANE, mkLane(2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd1));
    regWrite(4'd4, 32'hFFFF_FFFF);
    regWrite(4'd5, 32'hFFFF_FFFE);
    expectReg("R10 preload does not flag", A_STAT, 32'h0);
    pulse(16'h0040, 3);
    expectReg("R10 wrapped value", 4'd5, 32'd1);
    expectReg("R10 flag set", A_STAT, 32'h20);
    regWrite(A_STAT, 32'h0);
    expectReg("R10 write 0 keeps flag", A_STAT, 32'h20);
    regWrite(A_STAT, 32'h20);
    expectReg("R10 write 1 clears flag", A_STAT, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_count();
    t_share();
    t_free();
    t_cfg_next();
    t_preload();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule